// File: doc/BRIEF.md
# Dual-Role SPI Serial Port

This block is a byte-wide synchronous serial port that acts either as the clock-driving end of an SPI link or as the clock-following end. Software programs one 8-bit control register and a byte-wide data buffer. In the driving role a write to the buffer starts an exchange of eight bits, most significant bit first. The serial clock comes either from the system clock through a fixed prescaler or from an external timer pulse stream. In the following role the port shifts on edges it sees on the clock pin. An active-low select input can gate it, or the port can ignore that input.

Every received byte lands in the buffer and sets a buffer-full indication, which a buffer read clears. Two sticky flags report misuse. One flags a buffer write made while a byte is still moving. The other flags a byte that completes in the following role while the buffer still holds unread data. That late byte is thrown away. Mode codes with no SPI meaning leave the port parked, with its data output driven low.

Top module: `sspi_port`

## Requirements
- R1: After reset the control register reads 0x00, the buffer reads 0x00, buffer-full is 0, and sck_oe and sdo_oe are 0. Control layout: bit 0 enable, bit 1 clock idle level, bits 5:2 mode code, bit 6 write-collision flag, bit 7 overflow flag. A control write loads all eight bits, and a flag written as 0 is cleared.
- R2: Mode codes 0000, 0001 and 0010 drive SCK with half-periods of 2, 8 and 32 system clocks. A buffer write accepted at clock edge E0 starts the transfer, and SCK toggles at edges E0+h, E0+2h, and so on up to E0+16h.
- R3: Mode code 0011 toggles SCK once for every cycle in which tmr_tick is high during a transfer, so SCK runs at half the tick rate. Without ticks SCK stays idle.
- R4: A driving transfer sends the written byte MSB first on sdo_out. It samples sdi at each leading SCK edge and moves to the next output bit at each trailing edge. After the eighth trailing edge the received byte is in the buffer and buffer-full is 1.
- R5: SCK rests at the level of control bit 1. The leading edge is the transition away from that level, and SCK is back at rest when a transfer ends.
- R6: A buffer write while a byte is still shifting sets bit 6, does not disturb the transfer in progress, and bit 6 stays set until software writes it to 0.
- R7: In the following role, a byte that completes while buffer-full is 1 sets bit 7. The buffer keeps its old value and buffer-full stays 1.
- R8: In the driving role a completed byte always replaces the buffer, even if it is unread, and bit 7 is never set.
- R9: In mode 0100, ss_n high tristates sdo_out and makes the port ignore SCK edges. Raising ss_n part way through a byte drops the partial bits, and the next byte after reselection is received whole.
- R10: In mode 0101 the port ignores ss_n and always drives sdo_out. It returns the byte loaded into the buffer, MSB first, while it receives.
- R11: With bit 0 clear, sck_oe and sdo_oe are 0 and a buffer write starts nothing.
- R12: With mode codes 0110 to 1111 and the port enabled, sdo_oe is 1, sdo_out is 0, sck_oe is 0, and a buffer write starts nothing.
- R13: A one-cycle buf_re pulse clears buffer-full. Slave-side pins pass through a two-stage synchronizer, so each slave SCK level must last at least 4 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_rdata | output | 8 | Control register contents |
| buf_we | input | 1 | Data buffer write strobe |
| buf_wdata | input | DW | Byte to transmit |
| buf_re | input | 1 | Buffer read strobe (clears buffer-full) |
| buf_rdata | output | DW | Last received byte |
| buf_full | output | 1 | Unread received byte present |
| tmr_tick | input | 1 | External timer pulse for mode 0011 |
| sck_in | input | 1 | Serial clock from pin (slave) |
| sck_out | output | 1 | Serial clock to pin (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data in |
| sdo_out | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| ss_n | input | 1 | Active-low slave select |

## Verification
The bench drives a buffer write in the middle of the slowest prescaler setting. A design that aborted or reloaded on that write would corrupt the bit-by-bit SCK/SDO comparison and would miss the sticky collision flag. It completes a slave byte while the buffer is unread, to catch a design that overwrites the old byte or drops buffer-full instead of discarding the new one. It also completes a master byte over an unread buffer, where a wrong design would raise overflow. A slave byte cut off by ss_n, followed by a full byte, exposes a bit counter that is not reset: the delivered value would come out shifted.

// File: rtl/sspi_pkg.sv
package sspi_pkg;

    localparam int CTRL_W    = 8;
    localparam int BASE_HALF = 2;   // half-period of the fastest prescaler setting

    typedef enum logic [1:0] {
        ROLE_IDLE   = 2'd0,
        ROLE_MASTER = 2'd1,
        ROLE_SLAVE  = 2'd2
    } role_e;

    typedef enum logic [1:0] {
        CLK_DIV4  = 2'd0,
        CLK_DIV16 = 2'd1,
        CLK_DIV64 = 2'd2,
        CLK_TMR   = 2'd3
    } mclk_e;

    typedef struct packed {
        logic       ovf;
        logic       wcol;
        logic [3:0] mode;
        logic       pol;
        logic       en;
    } ctrl_t;

    localparam logic [3:0] MODE_SLV_SS   = 4'b0100;
    localparam logic [3:0] MODE_SLV_FREE = 4'b0101;

    function automatic role_e role_of(input logic [3:0] m);
        if (m[3:2] == 2'b00)                          return ROLE_MASTER;
        else if (m == MODE_SLV_SS || m == MODE_SLV_FREE) return ROLE_SLAVE;
        else                                          return ROLE_IDLE;
    endfunction

    function automatic mclk_e mclk_of(input logic [3:0] m);
        return mclk_e'(m[1:0]);
    endfunction

    // half-period in system clocks: 2, 8, 32 for the three prescaler codes
    function automatic int half_clocks(input mclk_e s);
        return BASE_HALF << (2 * int'(s));
    endfunction

endpackage

// File: rtl/sspi_pinsync.sv
module sspi_pinsync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    output logic [W-1:0] synced
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= RST_VAL;
                    else     stage[0] <= pins;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= RST_VAL;
                    else     stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign synced = stage[STAGES-1];
endmodule

// File: rtl/sspi_clkgen.sv
module sspi_clkgen
    import sspi_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  mclk_e sel,
    input  logic  tmr_tick,
    output logic  half_tick
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = CW'(half_clocks(sel) - 1);

    always_ff @(posedge clk) begin
        if (rst || !run || sel == CLK_TMR) cnt <= '0;
        else if (cnt == last)              cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end

    always_comb begin
        if (!run)                half_tick = 1'b0;
        else if (sel == CLK_TMR) half_tick = tmr_tick;
        else                     half_tick = (cnt == last);
    end
endmodule

// File: rtl/sspi_shifter.sv
module sspi_shifter #(
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          load,
    input  logic [DW-1:0] ld_data,
    input  logic          lead,
    input  logic          trail,
    input  logic          sdi_bit,
    output logic          tx_bit,
    output logic [DW-1:0] rx_data,
    output logic          done,
    output logic          in_prog
);
    logic [DW-1:0] shreg;
    logic          samp;
    logic [BW-1:0] cnt;
    logic          last_bit;

    assign last_bit = (cnt == BW'(DW - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            samp  <= 1'b0;
            cnt   <= '0;
        end else if (clear) begin
            cnt   <= '0;
        end else if (load) begin
            shreg <= ld_data;
            cnt   <= '0;
        end else begin
            if (lead)  samp <= sdi_bit;
            if (trail) begin
                shreg <= {shreg[DW-2:0], samp};
                cnt   <= last_bit ? '0 : cnt + 1'b1;
            end
        end
    end

    assign tx_bit  = shreg[DW-1];
    assign rx_data = {shreg[DW-2:0], samp};
    assign done    = trail && last_bit && !clear && !load;
    assign in_prog = (cnt != '0);
endmodule

// File: rtl/sspi_port.sv
module sspi_port
    import sspi_pkg::*;
#(
    parameter int DW     = 8,
    parameter int STAGES = 2,
    localparam int DIV_W = $clog2(BASE_HALF << 4) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              buf_we,
    input  logic [DW-1:0]     buf_wdata,
    input  logic              buf_re,
    output logic [DW-1:0]     buf_rdata,
    output logic              buf_full,
    input  logic              tmr_tick,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo_out,
    output logic              sdo_oe,
    input  logic              ss_n
);
    ctrl_t         ctrl_q;
    role_e         role;
    logic          is_master, is_slave, gated, ss_block, slave_live;
    logic [2:0]    pins_s;
    logic          sck_s, sdi_s, ss_s, sck_d;
    logic          pin_rise, pin_fall, pin_lead, pin_trail;
    logic          half_tick, m_busy, m_phase, m_lead, m_trail, m_start;
    logic          eng_lead, eng_trail, eng_sdi, eng_load, eng_clear;
    logic          tx_bit, eng_done, in_prog, s_load, wcol_set;
    logic [DW-1:0] rx_data, buf_q;
    logic          full_q;

    assign role      = role_of(ctrl_q.mode);
    assign is_master = ctrl_q.en && role == ROLE_MASTER;
    assign is_slave  = ctrl_q.en && role == ROLE_SLAVE;
    assign gated     = ctrl_q.mode == MODE_SLV_SS;

    // slave-side pin synchronizer: {ss_n, sdi, sck}
    sspi_pinsync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pins   ({ss_n, sdi, sck_in}),
        .synced (pins_s)
    );
    assign {ss_s, sdi_s, sck_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end

    assign pin_rise   = sck_s && !sck_d;
    assign pin_fall   = !sck_s && sck_d;
    assign pin_lead   = ctrl_q.pol ? pin_fall : pin_rise;
    assign pin_trail  = ctrl_q.pol ? pin_rise : pin_fall;
    assign ss_block   = gated && ss_s;
    assign slave_live = is_slave && !ss_block;

    // master clock generation
    sspi_clkgen #(.CW(DIV_W)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .run       (m_busy),
        .sel       (mclk_of(ctrl_q.mode)),
        .tmr_tick  (tmr_tick),
        .half_tick (half_tick)
    );
    assign m_lead  = half_tick && !m_phase;
    assign m_trail = half_tick && m_phase;
    assign m_start = buf_we && is_master && !m_busy;

    always_ff @(posedge clk) begin
        if (rst || !is_master) begin
            m_busy  <= 1'b0;
            m_phase <= 1'b0;
        end else if (m_start) begin
            m_busy  <= 1'b1;
            m_phase <= 1'b0;
        end else if (m_busy) begin
            if (m_lead)   m_phase <= 1'b1;
            if (m_trail)  m_phase <= 1'b0;
            if (eng_done) m_busy  <= 1'b0;
        end
    end

    // shared shift engine
    assign s_load    = buf_we && is_slave && !in_prog;
    assign eng_load  = m_start || s_load;
    assign eng_clear = !ctrl_q.en || role == ROLE_IDLE || (is_slave && ss_block);
    assign eng_lead  = is_master ? m_lead  : (slave_live && pin_lead);
    assign eng_trail = is_master ? m_trail : (slave_live && pin_trail);
    assign eng_sdi   = is_master ? sdi : sdi_s;
    assign wcol_set  = buf_we && ((is_master && m_busy) || (is_slave && in_prog));

    sspi_shifter #(.DW(DW)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .clear   (eng_clear),
        .load    (eng_load),
        .ld_data (buf_wdata),
        .lead    (eng_lead),
        .trail   (eng_trail),
        .sdi_bit (eng_sdi),
        .tx_bit  (tx_bit),
        .rx_data (rx_data),
        .done    (eng_done),
        .in_prog (in_prog)
    );

    // control register, buffer and sticky flags
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            buf_q  <= '0;
            full_q <= 1'b0;
        end else begin
            if (ctrl_we)  ctrl_q      <= ctrl_t'(ctrl_wdata);
            if (wcol_set) ctrl_q.wcol <= 1'b1;
            if (buf_re)   full_q      <= 1'b0;
            if (eng_done) begin
                if (is_slave && full_q) begin
                    ctrl_q.ovf <= 1'b1;
                end else begin
                    buf_q  <= rx_data;
                    full_q <= 1'b1;
                end
            end
        end
    end

    assign ctrl_rdata = ctrl_q;
    assign buf_rdata  = buf_q;
    assign buf_full   = full_q;

    // pin drive
    assign sck_oe  = is_master;
    assign sck_out = ctrl_q.pol ^ (is_master && m_phase);
    assign sdo_oe  = ctrl_q.en && (role == ROLE_MASTER || role == ROLE_IDLE || slave_live);
    assign sdo_out = (is_master || slave_live) ? tx_bit : 1'b0;
endmodule

// File: rtl/sspi_port_chk.sv
module sspi_port_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ctrl_we,
    input logic [7:0]    ctrl_rdata,
    input logic          buf_re,
    input logic [DW-1:0] buf_rdata,
    input logic          buf_full,
    input logic          sck_out,
    input logic          sck_oe,
    input logic          sdo_out,
    input logic          sdo_oe,
    input logic          ss_n
);
    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)           cyc <= '0;
        else if (cyc != 3) cyc <= cyc + 1'b1;
    end

    // R11: a disabled port releases both driven pins
    assert_released_R11: assert property (@(posedge clk) disable iff (rst)
        !ctrl_rdata[0] |-> (!sck_oe && !sdo_oe));

    // R12: parked modes hold SDO low and never drive SCK
    assert_parked_R12: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rdata[0] && ctrl_rdata[5:2] >= 4'd6) |-> (sdo_oe && !sdo_out && !sck_oe));

    // R6: the collision flag persists until software writes it
    assert_wcol_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rdata[6] && !ctrl_we) |=> ctrl_rdata[6]);

    // R8: overflow cannot appear while the port drives the clock
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rdata[0] && ctrl_rdata[5:2] <= 4'd3 && !ctrl_we) |=> !$rose(ctrl_rdata[7]));

    // R7: an overflow leaves the held byte untouched
    assert_keep_old_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctrl_rdata[7]) && !$past(ctrl_we) && !$past(buf_re)) |-> ($stable(buf_rdata) && buf_full));

    // R5: a master byte completes with SCK at its rest level
    assert_idle_end_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(buf_full) && sck_oe) |-> (sck_out == ctrl_rdata[1]));

    // R9: a deselected gated slave leaves SDO floating
    assert_deselect_R9: assert property (@(posedge clk) disable iff (rst)
        (cyc == 3 && ctrl_rdata[0] && ctrl_rdata[5:2] == 4'b0100 &&
         ss_n && $past(ss_n) && $past(ss_n, 2)) |-> !sdo_oe);
endmodule

bind sspi_port sspi_port_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .ctrl_rdata (ctrl_rdata),
    .buf_re     (buf_re),
    .buf_rdata  (buf_rdata),
    .buf_full   (buf_full),
    .sck_out    (sck_out),
    .sck_oe     (sck_oe),
    .sdo_out    (sdo_out),
    .sdo_oe     (sdo_oe),
    .ss_n       (ss_n)
);

// File: tb/tb_sspi_port.sv
module tb_sspi_port;
    logic       clk = 0, rst = 1;
    logic       ctrl_we = 0, buf_we = 0, buf_re = 0, tmr_tick = 0;
    logic [7:0] ctrl_wdata = 0, buf_wdata = 0;
    logic [7:0] ctrl_rdata, buf_rdata;
    logic       buf_full, sck_out, sck_oe, sdo_out, sdo_oe;
    logic       s_sck = 0, s_sdi = 0, m_sdi = 0, ss_n = 1;
    logic       sdi;
    int         checks = 0, fails = 0;
    bit         finished = 0;

    // master-side behavioural reference
    bit         m_on = 0;
    int         m_cyc = 0, m_h = 2;
    logic [7:0] m_tx, m_rx;
    logic       m_pol;

    assign sdi = m_on ? m_sdi : s_sdi;

    always #4 clk = ~clk;

    sspi_port dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .buf_re(buf_re), .buf_rdata(buf_rdata), .buf_full(buf_full),
        .tmr_tick(tmr_tick), .sck_in(s_sck), .sck_out(sck_out), .sck_oe(sck_oe),
        .sdi(sdi), .sdo_out(sdo_out), .sdo_oe(sdo_oe), .ss_n(ss_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] cw(input logic en, input logic pol, input logic [3:0] mode);
        return {2'b00, mode, pol, en};
    endfunction

    task automatic ctrl_write(input logic [7:0] v);
        @(negedge clk); ctrl_wdata = v; ctrl_we = 1;
        @(negedge clk); ctrl_we = 0;
    endtask

    task automatic buf_write(input logic [7:0] v);
        @(negedge clk); buf_wdata = v; buf_we = 1;
        @(negedge clk); buf_we = 0;
    endtask

    task automatic buf_read();
        @(negedge clk); buf_re = 1;
        @(negedge clk); buf_re = 0;
    endtask

    task automatic m_xfer(input logic [7:0] tx, input logic [7:0] rx, input int h, input logic pol);
        @(negedge clk);
        m_tx = tx; m_rx = rx; m_h = h; m_pol = pol;
        m_sdi = rx[7]; m_cyc = -1; m_on = 1;
        buf_wdata = tx; buf_we = 1;
        @(negedge clk); buf_we = 0;
    endtask

    task automatic m_wait();
        while (m_on) @(negedge clk);
    endtask

    // cycle-by-cycle master reference: toggle count = edges since start / half-period
    always @(posedge clk) if (m_on) m_cyc = m_cyc + 1;

    always @(negedge clk) begin
        if (m_on && m_cyc >= 0) begin
            int ntog;
            ntog = m_cyc / m_h;
            if (ntog < 16) begin
                chk("R2/R5 sck", sck_out, m_pol ^ ntog[0]);
                chk("R4 sdo", sdo_out, m_tx[7 - ntog / 2]);
                m_sdi = m_rx[7 - ntog / 2];
            end else begin
                chk("R4 full", buf_full, 1);
                chk("R4 rx byte", buf_rdata, m_rx);
                chk("R5 sck rest", sck_out, m_pol);
                m_on = 0;
            end
        end
    end

    task automatic s_bits(input logic [7:0] mosi, input int n, output logic [7:0] miso);
        miso = 0;
        for (int i = 0; i < n; i++) begin
            s_sdi = mosi[7 - i];
            repeat (6) @(negedge clk);
            miso[7 - i] = sdo_out;
            s_sck = 1;
            repeat (6) @(negedge clk);
            s_sck = 0;
        end
        repeat (8) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] miso;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", ctrl_rdata, 8'h00);
        chk("R1 buf", buf_rdata, 8'h00);
        chk("R1 full", buf_full, 0);
        chk("R1 oe", {sck_oe, sdo_oe}, 2'b00);

        // R2/R4: div4, idle low
        ctrl_write(cw(1, 0, 4'b0000));
        m_xfer(8'hA5, 8'h5A, 2, 0); m_wait();

        // R5: idle high, div16
        ctrl_write(cw(1, 1, 4'b0001));
        @(negedge clk); chk("R5 idle high", sck_out, 1);
        m_xfer(8'h0F, 8'hF0, 8, 1); m_wait();

        // R8 + R6: div64 over an unread buffer, collision mid-transfer
        ctrl_write(cw(1, 0, 4'b0010));
        m_xfer(8'h81, 8'h7E, 32, 0);
        repeat (40) @(negedge clk);
        buf_write(8'hEE);
        chk("R6 wcol set", ctrl_rdata[6], 1);
        m_wait();
        repeat (3) @(negedge clk);
        chk("R6 wcol sticky", ctrl_rdata[6], 1);
        chk("R8 no ovf", ctrl_rdata[7], 0);
        chk("R8 overwrite", buf_rdata, 8'h7E);
        ctrl_write(cw(1, 0, 4'b0010));
        chk("R6 wcol cleared", ctrl_rdata[6], 0);

        // R13: read clears full
        buf_read();
        chk("R13 full cleared", buf_full, 0);

        // R3: timer-tick clock
        ctrl_write(cw(1, 0, 4'b0011));
        buf_write(8'hA5);
        repeat (5) @(negedge clk);
        chk("R3 no tick idle", sck_out, 0);
        for (int k = 0; k < 16; k++) begin
            s_sdi = 8'h3B >> (7 - k / 2);
            @(negedge clk); tmr_tick = 1;
            @(negedge clk); tmr_tick = 0;
            chk("R3 sck per tick", sck_out, (k + 1) % 2);
        end
        repeat (2) @(negedge clk);
        chk("R3 full", buf_full, 1);
        chk("R3 rx byte", buf_rdata, 8'h3B);
        buf_read();

        // R10: free slave, ss_n high ignored
        ss_n = 1;
        ctrl_write(cw(1, 0, 4'b0101));
        buf_write(8'h3C);
        chk("R10 sdo driven", sdo_oe, 1);
        s_bits(8'hC5, 8, miso);
        chk("R10 miso", miso, 8'h3C);
        chk("R10 rx byte", buf_rdata, 8'hC5);
        chk("R10 full", buf_full, 1);

        // R7: overflow
        s_bits(8'h11, 8, miso);
        chk("R7 ovf set", ctrl_rdata[7], 1);
        chk("R7 buffer kept", buf_rdata, 8'hC5);
        chk("R7 full kept", buf_full, 1);
        buf_read();
        chk("R13 full cleared slave", buf_full, 0);

        // R9: gated slave
        ctrl_write(cw(1, 0, 4'b0100));
        chk("R7 ovf cleared by write", ctrl_rdata[7], 0);
        repeat (4) @(negedge clk);
        chk("R9 sdo tristate", sdo_oe, 0);
        s_bits(8'h77, 8, miso);
        chk("R9 ignored while deselected", buf_full, 0);
        ss_n = 0;
        repeat (4) @(negedge clk);
        chk("R9 sdo driven selected", sdo_oe, 1);
        s_bits(8'hFF, 3, miso);
        ss_n = 1;
        repeat (4) @(negedge clk);
        ss_n = 0;
        repeat (4) @(negedge clk);
        chk("R9 partial dropped", buf_full, 0);
        s_bits(8'h96, 8, miso);
        chk("R9 whole byte after reselect", buf_rdata, 8'h96);
        chk("R9 full", buf_full, 1);
        buf_read();
        ss_n = 1;

        // R12: parked mode
        ctrl_write(cw(1, 0, 4'b0111));
        chk("R12 pins", {sdo_oe, sdo_out, sck_oe}, 3'b100);
        buf_write(8'h55);
        repeat (40) @(negedge clk);
        chk("R12 nothing started", {buf_full, sck_oe}, 2'b00);

        // R11: disabled
        ctrl_write(cw(0, 0, 4'b0000));
        chk("R11 released", {sck_oe, sdo_oe}, 2'b00);
        buf_write(8'h55);
        repeat (40) @(negedge clk);
        chk("R11 nothing started", {buf_full, sck_oe, sdo_oe}, 3'b000);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule